// File: doc/BRIEF.md
# Local Bus Chip-Select Region Decoder

This block sits on the FPGA side of a local bus that a PCI bridge drives. It splits that bus into four regions, one for each chip-select line. A write to region 0 passes its low byte to an 8-bit parallel configuration port and raises a one-cycle strobe. Region 1 is a 16-bit path to a test-bus controller: writes and reads turn into registered strobes, and read data comes back from the controller. Regions 2 and 3 are two independent 4 kB register windows. Each window accepts 64-bit accesses with per-byte enables and returns the stored value on read-back.

All outputs are registered, so the configuration path keeps up with the 50 MHz bus clock without wait states. An access that asserts more than one select is dropped. It also sets an error flag that stays set until reset.

Top module: `lbus_cs_decoder`

## Requirements
- R1: A write with cs_i == 4'b0001 drives cfg_wr_o high for exactly the next cycle, with cfg_data_o equal to wdata_i[7:0] in that cycle. A read to this region gives no strobe and no rvalid_o.
- R2: cfg_data_o changes only in a cycle where cfg_wr_o is high.
- R3: Configuration writes on consecutive cycles each produce their own strobe on consecutive cycles, with no wait state between them.
- R4: A write with cs_i == 4'b0010 drives tbc_wr_o high for the next cycle, with tbc_addr_o equal to addr_i and tbc_wdata_o equal to wdata_i[15:0].
- R5: A read with cs_i == 4'b0010 drives tbc_rd_o high for the next cycle with tbc_addr_o equal to addr_i. In the cycle after that, rvalid_o is high and rdata_o holds tbc_rdata_i zero-extended to 64 bits, as sampled while tbc_rd_o was high.
- R6: A write with cs_i == 4'b0100 (window 0) or 4'b1000 (window 1) updates the 64-bit word at addr_i[11:3]. Byte lane k, bits 8k+7..8k, changes only when be_i[k] is high.
- R7: A read to a window raises rvalid_o in the next cycle, with rdata_o holding the addressed word. rdata_o is zero whenever rvalid_o is low.
- R8: After reset, every window word reads zero and err_o, cfg_wr_o, tbc_wr_o, tbc_rd_o and rvalid_o are low.
- R9: The two windows have separate storage. A write to one window leaves the same offset in the other unchanged.
- R10: When more than one bit of cs_i is high, the access is ignored: no strobe, no rvalid_o, and no change to window contents.
- R11: err_o goes high in the cycle after any access with more than one chip select high, and stays high until reset.
- R12: A write or read with cs_i == 0 has no effect on any output or on window contents.
- R13: A cycle with wr_i and rd_i both high counts as a write. The write takes effect and no read response follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 4 | Chip selects, one per region |
| wr_i | input | 1 | Write request |
| rd_i | input | 1 | Read request |
| addr_i | input | 12 | Byte address within the region |
| be_i | input | 8 | Byte enables for window writes |
| wdata_i | input | 64 | Write data |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 64 | Read data, zero when not valid |
| cfg_data_o | output | 8 | Configuration byte |
| cfg_wr_o | output | 1 | Configuration byte strobe |
| tbc_addr_o | output | 12 | Test controller address |
| tbc_wdata_o | output | 16 | Test controller write data |
| tbc_wr_o | output | 1 | Test controller write strobe |
| tbc_rd_o | output | 1 | Test controller read strobe |
| tbc_rdata_i | input | 16 | Test controller read data |
| err_o | output | 1 | Sticky select-conflict flag |

## Verification
Each result has a fixed latency. The configuration strobe, the test controller strobes and window read data appear one cycle after the request edge. Test controller read data appears two cycles after it, and the conflict flag appears one cycle after the conflicting access. The driver records the cycle number at which it applies each access and queues every expected result with its due cycle. The monitor samples on the falling edge and pops a result only when the matching output fires. Any result seen early, seen late or never seen is reported as a miscompare, and so is any strobe that fires with no queued result.

// File: rtl/lbus_pkg.sv
package lbus_pkg;
  localparam int unsigned NUM_WIN = 2;

  typedef struct packed {
    logic               cfg_wr;
    logic               tbc_wr;
    logic               tbc_rd;
    logic [NUM_WIN-1:0] win_wr;
    logic [NUM_WIN-1:0] win_rd;
  } lbus_req_t;
endpackage

// File: rtl/lbus_cs_decode.sv
module lbus_cs_decode
  import lbus_pkg::*;
#(
  parameter int unsigned CS_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [CS_W-1:0] cs_i,
  input  logic            wr_i,
  input  logic            rd_i,
  output lbus_req_t       req_o,
  output logic            err_o
);
  localparam int unsigned CNT_W = $clog2(CS_W + 1);

  logic [CNT_W-1:0] n_sel;
  logic             conflict, single, rd_only;

  always_comb begin
    n_sel = '0;
    for (int i = 0; i < CS_W; i++) n_sel = n_sel + CNT_W'(cs_i[i]);
  end

  assign conflict = (n_sel > CNT_W'(1)) && (wr_i || rd_i);
  assign single   = (n_sel == CNT_W'(1));
  // write wins when both requests are raised
  assign rd_only  = rd_i & ~wr_i;

  always_comb begin
    req_o        = '0;
    req_o.cfg_wr = single & cs_i[0] & wr_i;
    req_o.tbc_wr = single & cs_i[1] & wr_i;
    req_o.tbc_rd = single & cs_i[1] & rd_only;
    for (int w = 0; w < NUM_WIN; w++) begin
      req_o.win_wr[w] = single & cs_i[2+w] & wr_i;
      req_o.win_rd[w] = single & cs_i[2+w] & rd_only;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       err_o <= 1'b0;
    else if (conflict) err_o <= 1'b1;
  end
endmodule

// File: rtl/lbus_cfg_port.sv
module lbus_cfg_port #(
  parameter int unsigned CFG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CFG_W-1:0] data_i,
  output logic [CFG_W-1:0] cfg_data_o,
  output logic             cfg_wr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_data_o <= '0;
      cfg_wr_o   <= 1'b0;
    end else begin
      cfg_wr_o <= wr_i;
      if (wr_i) cfg_data_o <= data_i;
    end
  end
endmodule

// File: rtl/lbus_tbc_port.sv
module lbus_tbc_port #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned TBC_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [TBC_W-1:0]  wdata_i,
  output logic [ADDR_W-1:0] tbc_addr_o,
  output logic [TBC_W-1:0]  tbc_wdata_o,
  output logic              tbc_wr_o,
  output logic              tbc_rd_o,
  input  logic [TBC_W-1:0]  tbc_rdata_i,
  output logic              rvalid_o,
  output logic [TBC_W-1:0]  rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tbc_addr_o  <= '0;
      tbc_wdata_o <= '0;
      tbc_wr_o    <= 1'b0;
      tbc_rd_o    <= 1'b0;
    end else begin
      tbc_wr_o <= wr_i;
      tbc_rd_o <= rd_i;
      if (wr_i || rd_i) tbc_addr_o <= addr_i;
      if (wr_i)         tbc_wdata_o <= wdata_i;
    end
  end

  // capture controller data while the read strobe is up
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= tbc_rd_o;
      rdata_o  <= tbc_rd_o ? tbc_rdata_i : '0;
    end
  end
endmodule

// File: rtl/lbus_reg_window.sv
module lbus_reg_window #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned IDX_W  = 9
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [DATA_W/8-1:0] be_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic                rvalid_o,
  output logic [DATA_W-1:0]   rdata_o
);
  localparam int unsigned BE_W  = DATA_W / 8;
  localparam int unsigned WORDS = 1 << IDX_W;

  logic [DATA_W-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < WORDS; w++) mem_q[w] <= '0;
    end else if (wr_i) begin
      for (int b = 0; b < BE_W; b++)
        if (be_i[b]) mem_q[idx_i][b*8 +: 8] <= wdata_i[b*8 +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_i;
      rdata_o  <= rd_i ? mem_q[idx_i] : '0;
    end
  end
endmodule

// File: rtl/lbus_cs_decoder.sv
module lbus_cs_decoder
  import lbus_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CFG_W  = 8,
  parameter int unsigned TBC_W  = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [3:0]          cs_i,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W/8-1:0] be_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic                rvalid_o,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [CFG_W-1:0]    cfg_data_o,
  output logic                cfg_wr_o,
  output logic [ADDR_W-1:0]   tbc_addr_o,
  output logic [TBC_W-1:0]    tbc_wdata_o,
  output logic                tbc_wr_o,
  output logic                tbc_rd_o,
  input  logic [TBC_W-1:0]    tbc_rdata_i,
  output logic                err_o
);
  localparam int unsigned LANE_W = $clog2(DATA_W / 8);
  localparam int unsigned IDX_W  = ADDR_W - LANE_W;

  lbus_req_t         req;
  logic              tbc_rv;
  logic [TBC_W-1:0]  tbc_rd_data;
  logic [NUM_WIN-1:0] win_rv;
  logic [DATA_W-1:0] win_rd_data [NUM_WIN];

  lbus_cs_decode #(.CS_W(4)) u_decode (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cs_i  (cs_i),
    .wr_i  (wr_i),
    .rd_i  (rd_i),
    .req_o (req),
    .err_o (err_o)
  );

  lbus_cfg_port #(.CFG_W(CFG_W)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (req.cfg_wr),
    .data_i    (wdata_i[CFG_W-1:0]),
    .cfg_data_o(cfg_data_o),
    .cfg_wr_o  (cfg_wr_o)
  );

  lbus_tbc_port #(.ADDR_W(ADDR_W), .TBC_W(TBC_W)) u_tbc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (req.tbc_wr),
    .rd_i       (req.tbc_rd),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i[TBC_W-1:0]),
    .tbc_addr_o (tbc_addr_o),
    .tbc_wdata_o(tbc_wdata_o),
    .tbc_wr_o   (tbc_wr_o),
    .tbc_rd_o   (tbc_rd_o),
    .tbc_rdata_i(tbc_rdata_i),
    .rvalid_o   (tbc_rv),
    .rdata_o    (tbc_rd_data)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    lbus_reg_window #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_win (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (req.win_wr[w]),
      .rd_i    (req.win_rd[w]),
      .idx_i   (addr_i[ADDR_W-1:LANE_W]),
      .be_i    (be_i),
      .wdata_i (wdata_i),
      .rvalid_o(win_rv[w]),
      .rdata_o (win_rd_data[w])
    );
  end

  // sources are zero when idle, so an OR merges them
  always_comb begin
    rvalid_o = tbc_rv;
    rdata_o  = {{(DATA_W-TBC_W){1'b0}}, tbc_rd_data};
    for (int w = 0; w < NUM_WIN; w++) begin
      rvalid_o = rvalid_o | win_rv[w];
      rdata_o  = rdata_o | win_rd_data[w];
    end
  end
endmodule

// File: rtl/lbus_cs_decoder_chk.sv
module lbus_cs_decoder_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] cs_i,
  input logic       wr_i,
  input logic       rd_i,
  input logic [7:0] cfg_data_o,
  input logic       cfg_wr_o,
  input logic       tbc_wr_o,
  input logic       tbc_rd_o,
  input logic       rvalid_o,
  input logic       err_o
);
  AST_CFG_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_o == $past(cs_i == 4'b0001 && wr_i)); // R1
  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_wr_o |-> $stable(cfg_data_o)); // R2
  AST_TBC_WR_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbc_wr_o == $past(cs_i == 4'b0010 && wr_i)); // R4
  AST_TBC_RD_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbc_rd_o == $past(cs_i == 4'b0010 && rd_i && !wr_i)); // R5
  AST_CONFLICT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(cs_i) > 1) |=> !cfg_wr_o && !tbc_wr_o && !tbc_rd_o); // R10
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cfg_wr_o, tbc_wr_o, tbc_rd_o})); // R10
  AST_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(cs_i) > 1 && (wr_i || rd_i)) |=> err_o); // R11
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R11
  AST_NO_SEL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i == 4'b0000) |=> !cfg_wr_o && !tbc_wr_o && !tbc_rd_o); // R12
  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && rd_i && (cs_i == 4'b0100 || cs_i == 4'b1000)) |=> !rvalid_o); // R13
endmodule

bind lbus_cs_decoder lbus_cs_decoder_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_i      (cs_i),
  .wr_i      (wr_i),
  .rd_i      (rd_i),
  .cfg_data_o(cfg_data_o),
  .cfg_wr_o  (cfg_wr_o),
  .tbc_wr_o  (tbc_wr_o),
  .tbc_rd_o  (tbc_rd_o),
  .rvalid_o  (rvalid_o),
  .err_o     (err_o)
);

// File: tb/tb_lbus_cs_decoder.sv
module tb_lbus_cs_decoder;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  cs_i = '0;
  logic        wr_i = 1'b0, rd_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [7:0]  be_i = '0;
  logic [63:0] wdata_i = '0;
  logic        rvalid_o, cfg_wr_o, tbc_wr_o, tbc_rd_o, err_o;
  logic [63:0] rdata_o;
  logic [7:0]  cfg_data_o;
  logic [11:0] tbc_addr_o;
  logic [15:0] tbc_wdata_o, tbc_rdata_i;

  lbus_cs_decoder dut (.*);

  always #10 clk_i = ~clk_i;

  function automatic logic [15:0] tbc_resp(logic [11:0] a);
    return 16'hC000 ^ {4'h0, a};
  endfunction
  assign tbc_rdata_i = tbc_resp(tbc_addr_o);

  typedef struct {
    int          due;
    logic [63:0] data;
    logic [11:0] addr;
    string       req;
  } item_t;

  item_t q_cfg[$], q_tbw[$], q_tbr[$], q_rd[$];
  logic [63:0] mdl [2][512];
  int cyc = 0, n_chk = 0, n_fail = 0;
  logic [7:0] last_cfg = '0;
  bit done = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: pops expected items as results appear
  always @(negedge clk_i) if (rst_ni) begin
    item_t it;
    if (cfg_wr_o) begin
      if (q_cfg.size() == 0) chk(0, "R1 unexpected cfg strobe", 64'(cfg_data_o), 0);
      else begin
        it = q_cfg.pop_front();
        chk(it.due == cyc && cfg_data_o == it.data[7:0], it.req, 64'(cfg_data_o), it.data);
      end
      last_cfg = cfg_data_o;
    end else if (cfg_data_o != last_cfg)
      chk(0, "R2 cfg byte moved without strobe", 64'(cfg_data_o), 64'(last_cfg));
    if (tbc_wr_o) begin
      if (q_tbw.size() == 0) chk(0, "R4 unexpected tbc write", 64'(tbc_wdata_o), 0);
      else begin
        it = q_tbw.pop_front();
        chk(it.due == cyc && tbc_wdata_o == it.data[15:0] && tbc_addr_o == it.addr,
            it.req, {36'h0, tbc_addr_o, tbc_wdata_o}, {36'h0, it.addr, it.data[15:0]});
      end
    end
    if (tbc_rd_o) begin
      if (q_tbr.size() == 0) chk(0, "R5 unexpected tbc read", 64'(tbc_addr_o), 0);
      else begin
        it = q_tbr.pop_front();
        chk(it.due == cyc && tbc_addr_o == it.addr, it.req, 64'(tbc_addr_o), 64'(it.addr));
      end
    end
    if (rvalid_o) begin
      if (q_rd.size() == 0) chk(0, "R10 unexpected rvalid", rdata_o, 0);
      else begin
        it = q_rd.pop_front();
        chk(it.due == cyc && rdata_o == it.data, it.req, rdata_o, it.data);
      end
    end else if (rdata_o != '0)
      chk(0, "R7 rdata nonzero while idle", rdata_o, 0);
  end

  // driver: one access per call, applied at the falling edge
  task automatic acc(logic [3:0] cs, bit wr, bit rd, logic [11:0] a,
                     logic [7:0] be, logic [63:0] d, string req);
    item_t it;
    @(negedge clk_i);
    cs_i = cs; wr_i = wr; rd_i = rd; addr_i = a; be_i = be; wdata_i = d;
    it.req = req; it.addr = a; it.due = cyc + 1; it.data = d;
    if ($countones(cs) == 1) begin
      if (cs == 4'b0001 && wr) q_cfg.push_back(it);
      else if (cs == 4'b0010 && wr) q_tbw.push_back(it);
      else if (cs == 4'b0010 && rd) begin
        q_tbr.push_back(it);
        it.due = cyc + 2;
        it.data = {48'h0, tbc_resp(a)};
        q_rd.push_back(it);
      end else if (cs[3:2] != 2'b00) begin
        int w = cs[3] ? 1 : 0;
        if (wr) begin
          for (int b = 0; b < 8; b++)
            if (be[b]) mdl[w][a[11:3]][b*8 +: 8] = d[b*8 +: 8];
        end else if (rd) begin
          it.data = mdl[w][a[11:3]];
          q_rd.push_back(it);
        end
      end
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      cs_i = '0; wr_i = 0; rd_i = 0; be_i = '0;
    end
  endtask

  initial begin
    for (int w = 0; w < 2; w++)
      for (int i = 0; i < 512; i++) mdl[w][i] = '0;
    repeat (3) @(negedge clk_i);
    // R8: reset state
    chk(!cfg_wr_o && !tbc_wr_o && !tbc_rd_o && !rvalid_o && !err_o, "R8 reset outputs",
        {59'h0, cfg_wr_o, tbc_wr_o, tbc_rd_o, rvalid_o, err_o}, 0);
    rst_ni = 1'b1;
    idle(2);
    acc(4'b0100, 0, 1, 12'h010, 8'h00, 0, "R8 window0 reads zero");
    acc(4'b1000, 0, 1, 12'hFF8, 8'h00, 0, "R8 window1 reads zero");
    idle(2);
    // R1 R3: back-to-back configuration bytes
    acc(4'b0001, 1, 0, 12'h000, 8'h00, 64'hA5, "R1 cfg byte");
    acc(4'b0001, 1, 0, 12'h000, 8'h00, 64'h3C, "R3 cfg byte 2");
    acc(4'b0001, 1, 0, 12'h000, 8'h00, 64'hFFFF_FF0F, "R3 cfg byte 3");
    acc(4'b0001, 0, 1, 12'h000, 8'h00, 0, "R1 cfg read ignored");
    idle(4);
    // R4 R5: test controller path
    acc(4'b0010, 1, 0, 12'h123, 8'h00, 64'h1234_BEEF, "R4 tbc write");
    acc(4'b0010, 0, 1, 12'h044, 8'h00, 0, "R5 tbc read");
    idle(4);
    // R6 R7 R9: windows
    acc(4'b0100, 1, 0, 12'h018, 8'hFF, 64'h1122_3344_5566_7788, "R6 full write");
    acc(4'b0100, 0, 1, 12'h018, 8'h00, 0, "R7 read back");
    acc(4'b0100, 1, 0, 12'h01F, 8'b1000_0101, 64'hAAAA_BBBB_CCCC_DDDD, "R6 lane write");
    acc(4'b0100, 0, 1, 12'h018, 8'h00, 0, "R6 lanes merged");
    acc(4'b1000, 1, 0, 12'h018, 8'hFF, 64'hDEAD_BEEF_0BAD_F00D, "R9 window1 write");
    acc(4'b0100, 0, 1, 12'h018, 8'h00, 0, "R9 window0 unchanged");
    acc(4'b1000, 0, 1, 12'h018, 8'h00, 0, "R9 window1 read");
    acc(4'b1000, 0, 1, 12'hFFF, 8'h00, 0, "R7 top word");
    // R13: write wins
    acc(4'b1000, 1, 1, 12'h100, 8'h0F, 64'h0000_0000_7777_6666, "R13 wr+rd");
    acc(4'b1000, 0, 1, 12'h100, 8'h00, 0, "R13 write took effect");
    idle(3);
    chk(!err_o, "R11 no error yet", 64'(err_o), 0);
    // R10 R11: conflicting selects
    acc(4'b0101, 1, 0, 12'h018, 8'hFF, 64'h0, "R10 conflict write");
    idle(1);
    chk(err_o, "R11 error set", 64'(err_o), 1);
    acc(4'b1100, 0, 1, 12'h018, 8'h00, 0, "R10 conflict read");
    acc(4'b0110, 1, 0, 12'h018, 8'hFF, 64'h0, "R10 conflict tbc");
    acc(4'b0100, 0, 1, 12'h018, 8'h00, 0, "R10 window0 kept");
    // R12: no select
    acc(4'b0000, 1, 0, 12'h018, 8'hFF, 64'h0, "R12 no select write");
    acc(4'b0000, 0, 1, 12'h018, 8'h00, 0, "R12 no select read");
    acc(4'b0100, 0, 1, 12'h018, 8'h00, 0, "R12 window0 kept");
    idle(6);
    chk(err_o, "R11 error sticky", 64'(err_o), 1);
    chk(q_cfg.size() == 0, "R1 cfg strobes missing", 64'(q_cfg.size()), 0);
    chk(q_tbw.size() == 0, "R4 tbc writes missing", 64'(q_tbw.size()), 0);
    chk(q_tbr.size() == 0, "R5 tbc reads missing", 64'(q_tbr.size()), 0);
    chk(q_rd.size() == 0, "R7 read responses missing", 64'(q_rd.size()), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired act=%0d exp=done", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule